// File: doc/BRIEF.md
# Halt-State Wakeup Event Sequencer

This block tracks whether a processor core is halted. When a wakeup event arrives during halt, it decides the immediate action. It also tracks the handler context that follows the action, and so whether and when the core falls back into halt. A single strobe moves the running core into halt. While halted, the core reacts to twelve event strobes:

- maskable interrupt
- non-maskable interrupt
- init
- reset
- stop-clock assert
- stop-clock deassert
- SMI
- flush
- snoop address strobe
- bus-init
- hard failure
- redundancy-check error

Handler bodies are not modelled. Entering a handler is shown by an action code, and leaving one is shown by a return strobe.

Each wakeup source has its own rule for returning to halt:

- **Returns at once:** flush and snoop bounce straight back into halt.
- **Waits for deassert:** stop-clock holds the core out of halt until the clock request is withdrawn.
- **Depends on a stored bit:** a resume from system management mode re-halts only when the SMRAM restart bit is set.
- **Never returns:** interrupts, init/reset and machine-check events leave the core running.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset the core is running: `halted` is 0, `act_valid` is 0 and `act_code` is 0. While running, a `halt_req` pulse sets `halted` to 1 at the next clock edge.
- R2: When halted, `ev_intr` gives action code 1 and `ev_nmi` gives action code 2. The core then sits in an interrupt context. There, `iret_stb` returns it to running, not to halt.
- R3: When halted, `ev_reset` or `ev_init` gives action code 3, and the core goes to running.
- R4: When halted, `ev_binit`, `ev_hardfail` or `ev_frcerr` gives action code 8 (machine-check entry), and the core goes to running.
- R5: When halted, `ev_stpclk_on` gives action code 4. The core stays out of halt until `ev_stpclk_off`, which re-halts it at the next edge with no action pulse.
- R6: When halted, `ev_smi` gives action code 5. In that context, `rsm_stb` re-halts the core if `smram_halt_restart` is 1 and makes it run if it is 0.
- R7: When halted, `ev_flush` gives action code 6 and `ev_snoop` gives action code 7. The core is out of halt for exactly one cycle and then halted again.
- R8: If events coincide during halt, the first match in this order wins: reset, init, machine-check group, SMI, NMI, maskable interrupt, stop-clock assert, flush, snoop.
- R9: `act_valid` is high for exactly one cycle per action. This is the cycle after the edge that sampled the event, and `act_code` holds the code during it. `act_code` is 0 whenever `act_valid` is 0.
- R10: The block ignores these inputs:
  - event strobes when the core is not halted;
  - `halt_req` outside the running state;
  - `iret_stb` outside an interrupt context;
  - `rsm_stb` outside the management-mode context;
  - `ev_stpclk_off` outside the stop-clock context.

  Leaving halt always comes with an action pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt-entry strobe, taken while running |
| ev_intr | input | 1 | Maskable interrupt strobe |
| ev_nmi | input | 1 | Non-maskable interrupt strobe |
| ev_init | input | 1 | Init strobe |
| ev_reset | input | 1 | Reset event strobe |
| ev_stpclk_on | input | 1 | Stop-clock request asserted |
| ev_stpclk_off | input | 1 | Stop-clock request withdrawn |
| ev_smi | input | 1 | System management interrupt strobe |
| ev_flush | input | 1 | Cache flush request strobe |
| ev_snoop | input | 1 | Snoop address strobe |
| ev_binit | input | 1 | Bus-init strobe |
| ev_hardfail | input | 1 | Hard failure strobe |
| ev_frcerr | input | 1 | Redundancy-check error strobe |
| iret_stb | input | 1 | Return from interrupt handler |
| rsm_stb | input | 1 | Resume from management-mode handler |
| smram_halt_restart | input | 1 | Stored bit: re-halt on resume |
| act_valid | output | 1 | Action code valid strobe |
| act_code | output | 4 | Immediate action code |
| halted | output | 1 | Core is in the halt state |

## Verification
The assertions observe only the ports, so they rest on two assumptions. The first is that an event held during halt is seen by the design in the cycle it is sampled. The second is that no action can be issued two cycles in a row, because the core is never halted in the cycle just after an action. The stimulus respects these assumptions by pulsing every strobe for exactly one cycle and by never pulsing return strobes in the same cycle as an event. The priority checks force the block back to the running state with the reset pin after each coincidence, so that every pattern starts from a clean halt.

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              ev_intr,
  input  logic              ev_nmi,
  input  logic              ev_init,
  input  logic              ev_reset,
  input  logic              ev_stpclk_on,
  input  logic              ev_stpclk_off,
  input  logic              ev_smi,
  input  logic              ev_flush,
  input  logic              ev_snoop,
  input  logic              ev_binit,
  input  logic              ev_hardfail,
  input  logic              ev_frcerr,
  input  logic              iret_stb,
  input  logic              rsm_stb,
  input  logic              smram_halt_restart,
  output logic              act_valid,
  output logic [CODE_W-1:0] act_code,
  output logic              halted
);

  typedef enum logic [2:0] {
    S_RUN, S_HALTED, S_IN_INTR, S_IN_SMM, S_STOPCLK, S_ACK_RETURN
  } state_t;

  localparam logic [CODE_W-1:0] A_NONE  = CODE_W'(0);
  localparam logic [CODE_W-1:0] A_INTR  = CODE_W'(1);
  localparam logic [CODE_W-1:0] A_NMI   = CODE_W'(2);
  localparam logic [CODE_W-1:0] A_RESET = CODE_W'(3);
  localparam logic [CODE_W-1:0] A_STPCK = CODE_W'(4);
  localparam logic [CODE_W-1:0] A_SMM   = CODE_W'(5);
  localparam logic [CODE_W-1:0] A_FLUSH = CODE_W'(6);
  localparam logic [CODE_W-1:0] A_SNOOP = CODE_W'(7);
  localparam logic [CODE_W-1:0] A_MCHK  = CODE_W'(8);

  state_t            st, nxt;
  logic [CODE_W-1:0] code;
  logic              mchk_ev;

  assign mchk_ev = ev_binit | ev_hardfail | ev_frcerr;

  always_comb begin
    nxt  = st;
    code = A_NONE;
    case (st)
      S_RUN:        if (halt_req) nxt = S_HALTED;
      S_HALTED: begin
        if (ev_reset || ev_init) begin code = A_RESET; nxt = S_RUN;        end
        else if (mchk_ev)        begin code = A_MCHK;  nxt = S_RUN;        end
        else if (ev_smi)         begin code = A_SMM;   nxt = S_IN_SMM;     end
        else if (ev_nmi)         begin code = A_NMI;   nxt = S_IN_INTR;    end
        else if (ev_intr)        begin code = A_INTR;  nxt = S_IN_INTR;    end
        else if (ev_stpclk_on)   begin code = A_STPCK; nxt = S_STOPCLK;    end
        else if (ev_flush)       begin code = A_FLUSH; nxt = S_ACK_RETURN; end
        else if (ev_snoop)       begin code = A_SNOOP; nxt = S_ACK_RETURN; end
      end
      S_IN_INTR:    if (iret_stb) nxt = S_RUN;
      S_IN_SMM:     if (rsm_stb) nxt = smram_halt_restart ? S_HALTED : S_RUN;
      S_STOPCLK:    if (ev_stpclk_off) nxt = S_HALTED;
      S_ACK_RETURN: nxt = S_HALTED;
      default:      nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      act_valid <= 1'b0;
      act_code  <= A_NONE;
    end else begin
      st        <= nxt;
      act_valid <= (code != A_NONE);
      act_code  <= code;
    end
  end

  assign halted = (st == S_HALTED);

endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_reset,
  input logic              act_valid,
  input logic [CODE_W-1:0] act_code,
  input logic              halted
);

  AST_ACT_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(halted)); // R10
  AST_LEAVE_WITH_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> act_valid); // R10
  AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> !act_valid); // R9
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> act_code == CODE_W'(0)); // R9
  AST_ACK_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (act_code == CODE_W'(6) || act_code == CODE_W'(7))) |=> halted); // R7
  AST_MCHK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == CODE_W'(8)) |=> !halted); // R4
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && ev_reset) |=> (act_valid && act_code == CODE_W'(3))); // R3
  AST_REHALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !act_valid); // R5

endmodule

bind halt_wake_seq halt_wake_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset),
  .act_valid(act_valid), .act_code(act_code), .halted(halted)
);

// File: tb/tb_halt_wake_seq.sv
module tb_halt_wake_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, iret_stb = 1'b0, rsm_stb = 1'b0, smram_bit = 1'b0;
  logic [11:0] ev = '0;
  logic act_valid, halted;
  logic [3:0] act_code;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  localparam logic [11:0] M_RST = 12'h001, M_INIT = 12'h002, M_BINIT = 12'h004,
    M_HARD = 12'h008, M_FRC = 12'h010, M_SMI = 12'h020, M_NMI = 12'h040,
    M_INTR = 12'h080, M_STON = 12'h100, M_FLUSH = 12'h200, M_SNOOP = 12'h400,
    M_STOFF = 12'h800;

  always #4 clk = ~clk;

  halt_wake_seq dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
    .ev_intr(ev[7]), .ev_nmi(ev[6]), .ev_init(ev[1]), .ev_reset(ev[0]),
    .ev_stpclk_on(ev[8]), .ev_stpclk_off(ev[11]), .ev_smi(ev[5]),
    .ev_flush(ev[9]), .ev_snoop(ev[10]), .ev_binit(ev[2]),
    .ev_hardfail(ev[3]), .ev_frcerr(ev[4]),
    .iret_stb(iret_stb), .rsm_stb(rsm_stb), .smram_halt_restart(smram_bit),
    .act_valid(act_valid), .act_code(act_code), .halted(halted)
  );

  task automatic check(string req, logic ev_v, logic [3:0] ec, logic eh);
    vectors++;
    if (act_valid !== ev_v || act_code !== ec || halted !== eh) begin
      miscompares++;
      $display("FAIL %s actual valid=%b code=%0d halted=%b expected valid=%b code=%0d halted=%b",
               req, act_valid, act_code, halted, ev_v, ec, eh);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ev = '0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic go_halt(string req);
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    check(req, 1'b0, 4'd0, 1'b1);
  endtask

  task automatic fire(string req, logic [11:0] m, logic [3:0] ec);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
    check(req, 1'b1, ec, 1'b0);
  endtask

  task automatic pulse_iret();
    @(negedge clk); iret_stb = 1'b1; @(negedge clk); iret_stb = 1'b0;
  endtask

  task automatic pulse_rsm();
    @(negedge clk); rsm_stb = 1'b1; @(negedge clk); rsm_stb = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 reset", 1'b0, 4'd0, 1'b0);
    go_halt("R1 halt entry");
  endtask

  task automatic t_interrupts();
    fire("R2 intr", M_INTR, 4'd1);
    @(negedge clk); check("R9 single pulse", 1'b0, 4'd0, 1'b0);
    go_halt_ignored("R10 halt_req in intr");
    pulse_iret(); check("R2 iret no halt", 1'b0, 4'd0, 1'b0);
    go_halt("R2 back to run");
    fire("R2 nmi", M_NMI, 4'd2);
    pulse_iret(); check("R2 nmi iret", 1'b0, 4'd0, 1'b0);
    go_halt("R2 run after nmi");
  endtask

  task automatic go_halt_ignored(string req);
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    check(req, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_reset_init();
    fire("R3 reset ev", M_RST, 4'd3);
    @(negedge clk); check("R3 stays run", 1'b0, 4'd0, 1'b0);
    go_halt("R3 run after reset");
    fire("R3 init ev", M_INIT, 4'd3);
    go_halt("R3 run after init");
  endtask

  task automatic t_mchk();
    fire("R4 binit", M_BINIT, 4'd8);
    @(negedge clk); check("R4 no rehalt", 1'b0, 4'd0, 1'b0);
    go_halt("R4 run after binit");
    fire("R4 hardfail", M_HARD, 4'd8);
    go_halt("R4 run after hardfail");
    fire("R4 frcerr", M_FRC, 4'd8);
    go_halt("R4 run after frcerr");
  endtask

  task automatic t_stopclk();
    fire("R5 stpclk on", M_STON, 4'd4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R5 held out", 1'b0, 4'd0, 1'b0);
    end
    @(negedge clk); ev = M_STOFF;
    @(negedge clk); ev = '0;
    check("R5 stpclk off rehalt", 1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_smm();
    smram_bit = 1'b1;
    fire("R6 smi", M_SMI, 4'd5);
    pulse_iret(); check("R10 iret in smm", 1'b0, 4'd0, 1'b0);
    pulse_rsm(); check("R6 rsm bit1", 1'b0, 4'd0, 1'b1);
    smram_bit = 1'b0;
    fire("R6 smi again", M_SMI, 4'd5);
    pulse_rsm(); check("R6 rsm bit0", 1'b0, 4'd0, 1'b0);
    go_halt("R6 run after rsm");
  endtask

  task automatic t_ack_return();
    fire("R7 flush", M_FLUSH, 4'd6);
    @(negedge clk); check("R7 flush rehalt", 1'b0, 4'd0, 1'b1);
    fire("R7 snoop", M_SNOOP, 4'd7);
    @(negedge clk); check("R7 snoop rehalt", 1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_priority();
    logic [11:0] all;
    all = 12'h7FF;
    fire("R8 all", all, 4'd3); do_reset(); go_halt("R8 rehalt");
    fire("R8 init over mchk", all & ~M_RST, 4'd3); do_reset(); go_halt("R8 rehalt");
    fire("R8 mchk", M_HARD | M_SMI | M_NMI | M_INTR | M_STON | M_FLUSH | M_SNOOP, 4'd8);
    do_reset(); go_halt("R8 rehalt");
    fire("R8 smi", M_SMI | M_NMI | M_INTR | M_STON | M_FLUSH | M_SNOOP, 4'd5);
    do_reset(); go_halt("R8 rehalt");
    fire("R8 nmi", M_NMI | M_INTR | M_STON | M_FLUSH | M_SNOOP, 4'd2);
    do_reset(); go_halt("R8 rehalt");
    fire("R8 intr", M_INTR | M_STON | M_FLUSH | M_SNOOP, 4'd1);
    do_reset(); go_halt("R8 rehalt");
    fire("R8 stpclk", M_STON | M_FLUSH | M_SNOOP, 4'd4);
    do_reset(); go_halt("R8 rehalt");
    fire("R8 flush", M_FLUSH | M_SNOOP, 4'd6);
    @(negedge clk); check("R8 flush back", 1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_ignored();
    do_reset();
    @(negedge clk); ev = 12'h7FF;
    @(negedge clk); ev = '0;
    check("R10 events while running", 1'b0, 4'd0, 1'b0);
    go_halt("R10 halt after ignored");
    @(negedge clk); iret_stb = 1'b1; rsm_stb = 1'b1; ev = M_STOFF; halt_req = 1'b1;
    @(negedge clk); iret_stb = 1'b0; rsm_stb = 1'b0; ev = '0; halt_req = 1'b0;
    check("R10 strobes while halted", 1'b0, 4'd0, 1'b1);
    @(negedge clk); check("R10 still halted", 1'b0, 4'd0, 1'b1);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_interrupts();
    t_reset_init();
    t_mchk();
    t_stopclk();
    t_smm();
    t_ack_return();
    t_priority();
    t_ignored();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule